// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block feeds a MAC transmitter from memory. Software describes outgoing frames in a fixed ring of four entries. Each entry has three words: a status word, a length word and a control word. The control word carries the buffer base address, an enable flag, a done flag and a read-only copy of the engine's current ring position. Software fills in the length, then writes the control word with the enable flag set and the done flag clear. The engine picks entries up in ring order. For each entry it reads the buffer one byte at a time over a simple request/acknowledge port and hands the bytes to the MAC on a valid/ready stream, marking the final byte.

When the MAC reports that the frame has finished, the engine stores the MAC's result in the entry's status word. It then clears the enable flag, sets the done flag and moves on to the next entry. A level interrupt is the OR of all done flags. A one-cycle pulse marks every moment a done flag rises. Software clears a done flag by rewriting the control word with that flag at 0. The ring position that reads out after reset is a parameter and need not be zero, so software must read it before queuing the first frame.

Top module: `txring_dma`

## Requirements
- R1: After reset every entry has enable (control bit 0) and done (control bit 1) at 0, `irq` and `irq_pulse` are low, and the ring-position field (control bits 3:2) of every entry reads `CB_INIT`.
- R2: Entries are serviced in ring order starting at the ring position. The position advances by one on each completion and wraps from entry 3 to entry 0.
- R3: While the entry at the ring position has enable 0, the engine issues no memory reads and streams no bytes. It starts once that entry's control word is written with bit 0 set.
- R4: For a non-zero length, the engine reads length-word bits 10:0 bytes in ascending order. It starts at the base taken from control bits 31:5, with the low five address bits zero. It streams those bytes in order and asserts `tx_last` on the final one. Length bits above bit 10 are ignored.
- R5: One clock edge after `mac_done` is sampled, three things happen together: status bit 0 takes `mac_abort`, control bit 0 clears and control bit 1 sets.
- R6: An entry enabled with length 0 completes on the edge after the engine sees it enabled. Its status bit 0 is 1, and no memory read is issued and no byte is streamed.
- R7: Writing a control word with bit 1 at 0 clears done. Writing it with bit 1 at 1 never sets done.
- R8: `irq` is the OR of all done flags. `irq_pulse` is high for the one cycle after any done flag rises.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold. While `mem_rd_req` waits for `mem_rd_ack`, `mem_rd_addr` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word select: bits 3:2 entry, bits 1:0 word (0 status, 1 length, 2 control) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| mem_rd_req | output | 1 | Byte read request, held until acknowledged |
| mem_rd_addr | output | 32 | Byte address of the request |
| mem_rd_ack | input | 1 | Read acknowledge; `mem_rd_data` valid |
| mem_rd_data | input | 8 | Read data byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | MAC accepts the byte |
| mac_done | input | 1 | Frame finished (one-cycle pulse) |
| mac_abort | input | 1 | Frame was aborted, valid with `mac_done` |
| irq | output | 1 | OR of all done flags |
| irq_pulse | output | 1 | One-cycle pulse on any done flag rising |

## Verification
A control write with enable set is registered on its write edge. The engine sees it on the next edge, so a zero-length entry shows done set and enable clear two falling edges after the write strobe. The bench samples exactly there. Completion results (done, status and `irq_pulse`) are due one edge after `mac_done` is sampled. The bench's MAC model therefore checks `irq_pulse` on the following falling edge and checks that it has dropped one edge later. Streamed bytes have no fixed latency. The scoreboard compares each byte on the falling edge before the edge that accepts it, using the ready value it has just decided to drive.

// File: rtl/txring_pkg.sv
package txring_pkg;
    localparam int REG_W   = 32;
    localparam int EN_BIT  = 0;
    localparam int DN_BIT  = 1;
    localparam int CB_LSB  = 2;

    localparam logic [1:0] FLD_STAT = 2'd0;
    localparam logic [1:0] FLD_LEN  = 2'd1;
    localparam logic [1:0] FLD_CTRL = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SEND,
        ST_WAIT
    } eng_state_e;
endpackage

// File: rtl/txring_regs.sv
module txring_regs
    import txring_pkg::*;
#(
    parameter int N_ENT   = 4,
    parameter int LEN_W   = 11,
    parameter int ADDR_W  = 32,
    parameter int ALIGN_W = 5,
    localparam int IDX_W  = $clog2(N_ENT),
    localparam int BASE_W = ADDR_W - ALIGN_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W+1:0]          wr_addr,
    input  logic [REG_W-1:0]          wr_data,
    input  logic [IDX_W+1:0]          rd_addr,
    output logic [REG_W-1:0]          rd_data,
    input  logic [IDX_W-1:0]          cb,
    input  logic                      cmpl_valid,
    input  logic [IDX_W-1:0]          cmpl_idx,
    input  logic                      cmpl_abort,
    output logic [N_ENT-1:0]          en_vec,
    output logic [N_ENT-1:0]          dn_vec,
    output logic [N_ENT*LEN_W-1:0]    len_arr,
    output logic [N_ENT*BASE_W-1:0]   base_arr
);
    typedef struct packed {
        logic              en;
        logic              dn;
        logic              abort;
        logic [LEN_W-1:0]  len;
        logic [BASE_W-1:0] base;
    } ent_t;

    ent_t [N_ENT-1:0] ent_d, ent_q;

    logic unused_wdata;
    assign unused_wdata = ^wr_data;

    always_comb begin
        ent_d = ent_q;
        for (int i = 0; i < N_ENT; i++) begin
            if (wr_en && wr_addr[IDX_W+1:2] == IDX_W'(i)) begin
                case (wr_addr[1:0])
                    FLD_STAT: ent_d[i].abort = wr_data[0];
                    FLD_LEN:  ent_d[i].len   = wr_data[LEN_W-1:0];
                    FLD_CTRL: begin
                        ent_d[i].base = wr_data[ADDR_W-1:ALIGN_W];
                        ent_d[i].en   = wr_data[EN_BIT];
                        ent_d[i].dn   = ent_q[i].dn & wr_data[DN_BIT];
                    end
                    default: ;
                endcase
            end
            if (cmpl_valid && cmpl_idx == IDX_W'(i)) begin
                ent_d[i].en    = 1'b0;
                ent_d[i].dn    = 1'b1;
                ent_d[i].abort = cmpl_abort;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_out
        assign en_vec[g]                     = ent_q[g].en;
        assign dn_vec[g]                     = ent_q[g].dn;
        assign len_arr[g*LEN_W +: LEN_W]     = ent_q[g].len;
        assign base_arr[g*BASE_W +: BASE_W]  = ent_q[g].base;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr[1:0])
            FLD_STAT: rd_data[0] = ent_q[rd_addr[IDX_W+1:2]].abort;
            FLD_LEN:  rd_data[LEN_W-1:0] = ent_q[rd_addr[IDX_W+1:2]].len;
            FLD_CTRL: begin
                rd_data[ADDR_W-1:ALIGN_W] = ent_q[rd_addr[IDX_W+1:2]].base;
                rd_data[EN_BIT]           = ent_q[rd_addr[IDX_W+1:2]].en;
                rd_data[DN_BIT]           = ent_q[rd_addr[IDX_W+1:2]].dn;
                rd_data[CB_LSB +: IDX_W]  = cb;
            end
            default: ;
        endcase
    end

    // R5: a completion leaves the entry done with its enable dropped
    p_cmpl_marks_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_valid |=> (dn_vec[$past(cmpl_idx)] && !en_vec[$past(cmpl_idx)]));

    // R7: a done flag only rises through a completion
    p_dn_rise_needs_cmpl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(dn_vec) > $countones($past(dn_vec))) |-> $past(cmpl_valid));
endmodule

// File: rtl/txring_engine.sv
module txring_engine
    import txring_pkg::*;
#(
    parameter int N_ENT   = 4,
    parameter int LEN_W   = 11,
    parameter int ADDR_W  = 32,
    parameter int ALIGN_W = 5,
    parameter int CB_INIT = 2,
    localparam int IDX_W  = $clog2(N_ENT),
    localparam int BASE_W = ADDR_W - ALIGN_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_ENT-1:0]        en_vec,
    input  logic [N_ENT*LEN_W-1:0]  len_arr,
    input  logic [N_ENT*BASE_W-1:0] base_arr,
    output logic [IDX_W-1:0]        cb,
    output logic                    mem_rd_req,
    output logic [ADDR_W-1:0]       mem_rd_addr,
    input  logic                    mem_rd_ack,
    input  logic [7:0]              mem_rd_data,
    output logic                    tx_valid,
    output logic [7:0]              tx_data,
    output logic                    tx_last,
    input  logic                    tx_ready,
    input  logic                    mac_done,
    input  logic                    mac_abort,
    output logic                    cmpl_valid,
    output logic [IDX_W-1:0]        cmpl_idx,
    output logic                    cmpl_abort
);
    typedef struct packed {
        eng_state_e        st;
        logic [IDX_W-1:0]  cb;
        logic [ADDR_W-1:0] ptr;
        logic [LEN_W-1:0]  remain;
        logic [7:0]        data;
    } eng_t;

    eng_t eng_d, eng_q;

    logic              cur_en;
    logic [LEN_W-1:0]  cur_len;
    logic [BASE_W-1:0] cur_base;

    function automatic logic [IDX_W-1:0] ring_next(input logic [IDX_W-1:0] c);
        return (c == IDX_W'(N_ENT - 1)) ? '0 : c + 1'b1;
    endfunction

    assign cur_en   = en_vec[eng_q.cb];
    assign cur_len  = len_arr[int'(eng_q.cb)*LEN_W +: LEN_W];
    assign cur_base = base_arr[int'(eng_q.cb)*BASE_W +: BASE_W];

    always_comb begin
        eng_d      = eng_q;
        cmpl_valid = 1'b0;
        cmpl_abort = 1'b0;
        case (eng_q.st)
            ST_IDLE: begin
                if (cur_en) begin
                    if (cur_len == '0) begin
                        cmpl_valid = 1'b1;
                        cmpl_abort = 1'b1;
                        eng_d.cb   = ring_next(eng_q.cb);
                    end else begin
                        eng_d.st     = ST_FETCH;
                        eng_d.ptr    = {cur_base, {ALIGN_W{1'b0}}};
                        eng_d.remain = cur_len;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_rd_ack) begin
                    eng_d.data = mem_rd_data;
                    eng_d.st   = ST_SEND;
                end
            end
            ST_SEND: begin
                if (tx_ready) begin
                    eng_d.ptr    = eng_q.ptr + 1'b1;
                    eng_d.remain = eng_q.remain - 1'b1;
                    eng_d.st     = (eng_q.remain == LEN_W'(1)) ? ST_WAIT : ST_FETCH;
                end
            end
            ST_WAIT: begin
                if (mac_done) begin
                    cmpl_valid = 1'b1;
                    cmpl_abort = mac_abort;
                    eng_d.cb   = ring_next(eng_q.cb);
                    eng_d.st   = ST_IDLE;
                end
            end
            default: eng_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q.st     <= ST_IDLE;
            eng_q.cb     <= IDX_W'(CB_INIT);
            eng_q.ptr    <= '0;
            eng_q.remain <= '0;
            eng_q.data   <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign cb          = eng_q.cb;
    assign cmpl_idx    = eng_q.cb;
    assign mem_rd_req  = (eng_q.st == ST_FETCH);
    assign mem_rd_addr = eng_q.ptr;
    assign tx_valid    = (eng_q.st == ST_SEND);
    assign tx_data     = eng_q.data;
    assign tx_last     = (eng_q.remain == LEN_W'(1));

    // R9: a stalled byte is held until the MAC takes it
    p_stream_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R9: an outstanding read keeps its address
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R2: each completion moves the ring position by exactly one, with wrap
    p_cb_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_valid |=> (cb == (($past(cb) == IDX_W'(N_ENT - 1)) ? '0 : $past(cb) + 1'b1)));

    // R3: the ring position never moves without a completion
    p_cb_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cmpl_valid |=> $stable(cb));
endmodule

// File: rtl/txring_irq.sv
module txring_irq #(
    parameter int N_ENT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_ENT-1:0] dn_vec,
    output logic             irq,
    output logic             irq_pulse
);
    typedef struct packed {
        logic [N_ENT-1:0] dn_prev;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d.dn_prev = dn_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq       = |dn_vec;
    assign irq_pulse = |(dn_vec & ~irq_q.dn_prev);

    // R8: the level output rising is always accompanied by the pulse
    p_rise_has_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> irq_pulse);

    // R8: the pulse never appears with the level low
    p_pulse_in_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> irq);
endmodule

// File: rtl/txring_dma.sv
module txring_dma
    import txring_pkg::*;
#(
    parameter int N_ENT   = 4,
    parameter int LEN_W   = 11,
    parameter int ADDR_W  = 32,
    parameter int ALIGN_W = 5,
    parameter int CB_INIT = 2,
    localparam int IDX_W  = $clog2(N_ENT),
    localparam int BASE_W = ADDR_W - ALIGN_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [IDX_W+1:0]     reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic                 mem_rd_req,
    output logic [ADDR_W-1:0]    mem_rd_addr,
    input  logic                 mem_rd_ack,
    input  logic [7:0]           mem_rd_data,
    output logic                 tx_valid,
    output logic [7:0]           tx_data,
    output logic                 tx_last,
    input  logic                 tx_ready,
    input  logic                 mac_done,
    input  logic                 mac_abort,
    output logic                 irq,
    output logic                 irq_pulse
);
    logic [N_ENT-1:0]        en_vec;
    logic [N_ENT-1:0]        dn_vec;
    logic [N_ENT*LEN_W-1:0]  len_arr;
    logic [N_ENT*BASE_W-1:0] base_arr;
    logic [IDX_W-1:0]        cb;
    logic                    cmpl_valid;
    logic [IDX_W-1:0]        cmpl_idx;
    logic                    cmpl_abort;

    txring_regs #(
        .N_ENT(N_ENT), .LEN_W(LEN_W), .ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .wr_addr    (reg_addr),
        .wr_data    (reg_wdata),
        .rd_addr    (reg_addr),
        .rd_data    (reg_rdata),
        .cb         (cb),
        .cmpl_valid (cmpl_valid),
        .cmpl_idx   (cmpl_idx),
        .cmpl_abort (cmpl_abort),
        .en_vec     (en_vec),
        .dn_vec     (dn_vec),
        .len_arr    (len_arr),
        .base_arr   (base_arr)
    );

    txring_engine #(
        .N_ENT(N_ENT), .LEN_W(LEN_W), .ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W),
        .CB_INIT(CB_INIT)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_vec      (en_vec),
        .len_arr     (len_arr),
        .base_arr    (base_arr),
        .cb          (cb),
        .mem_rd_req  (mem_rd_req),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_ack  (mem_rd_ack),
        .mem_rd_data (mem_rd_data),
        .tx_valid    (tx_valid),
        .tx_data     (tx_data),
        .tx_last     (tx_last),
        .tx_ready    (tx_ready),
        .mac_done    (mac_done),
        .mac_abort   (mac_abort),
        .cmpl_valid  (cmpl_valid),
        .cmpl_idx    (cmpl_idx),
        .cmpl_abort  (cmpl_abort)
    );

    txring_irq #(
        .N_ENT(N_ENT)
    ) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .dn_vec    (dn_vec),
        .irq       (irq),
        .irq_pulse (irq_pulse)
    );
endmodule

// File: tb/txring_dma_bench.sv
module txring_dma_bench;
    localparam int CB_INIT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ack = 1'b0;
    logic [7:0]  mem_rd_data = '0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic        tx_ready = 1'b0;
    logic        mac_done = 1'b0;
    logic        mac_abort = 1'b0;
    logic        irq;
    logic        irq_pulse;

    int n_checks = 0;
    int n_fail = 0;
    int n_bytes = 0;
    int n_reqs = 0;
    int cyc = 0;
    bit finished = 0;

    logic [8:0] exp_q[$];
    logic       ab_q[$];

    always #5 clk = ~clk;

    txring_dma #(.CB_INIT(CB_INIT)) u_txring_dma (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .mac_done(mac_done), .mac_abort(mac_abort),
        .irq(irq), .irq_pulse(irq_pulse)
    );

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // memory model: one-cycle acknowledge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd_req) n_reqs <= n_reqs + 1;
        mem_rd_ack  <= mem_rd_req && !mem_rd_ack;
        mem_rd_data <= mem_byte(mem_rd_addr);
    end

    // MAC model and scoreboard monitor
    int  done_cnt = -1;
    logic pend_ab = 1'b0;
    int  pulse_chk = 0;
    always @(negedge clk) begin
        bit rdy;
        rdy = (cyc % 3) != 1;
        tx_ready <= rdy;
        mac_done <= 1'b0;
        if (pulse_chk == 2) begin
            chk(irq_pulse && irq, "R8 pulse one cycle after mac_done", {30'b0, irq, irq_pulse}, 32'h3);
            pulse_chk = 1;
        end else if (pulse_chk == 1) begin
            chk(!irq_pulse, "R8 pulse lasts one cycle", {31'b0, irq_pulse}, 32'h0);
            pulse_chk = 0;
        end
        if (done_cnt == 0) begin
            mac_done  <= 1'b1;
            mac_abort <= pend_ab;
            pulse_chk = 2;
            done_cnt = -1;
        end else if (done_cnt > 0) begin
            done_cnt--;
        end
        if (rst_n && tx_valid && rdy) begin
            n_bytes++;
            if (exp_q.size() == 0) begin
                chk(0, "R4 unexpected stream byte", {23'b0, tx_last, tx_data}, 32'h0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk({tx_last, tx_data} == e, "R4 stream byte/last", {23'b0, tx_last, tx_data}, {23'b0, e});
                if (tx_last) begin
                    pend_ab = (ab_q.size() != 0) ? ab_q.pop_front() : 1'b0;
                    done_cnt = 3;
                end
            end
        end
    end

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic queue_frame(input int ent, input logic [31:0] base, input logic [31:0] len, input logic ab);
        int n;
        n = int'(len[10:0]);
        for (int j = 0; j < n; j++) begin
            exp_q.push_back({(j == n - 1), mem_byte(base + 32'(j))});
        end
        ab_q.push_back(ab);
        reg_write(4'(ent * 4 + 0), 32'h0);
        reg_write(4'(ent * 4 + 1), len);
        reg_write(4'(ent * 4 + 2), base | 32'h1);
    endtask

    task automatic wait_done(input int ent);
        logic [31:0] d;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            reg_read(4'(ent * 4 + 2), d);
            if (d[1]) return;
        end
        chk(0, "R5 done never set", d, 32'h2);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int b0, r0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(!irq && !irq_pulse, "R1 irq low after reset", {30'b0, irq, irq_pulse}, 32'h0);
        chk(!tx_valid && !mem_rd_req, "R1 engine quiet after reset", {30'b0, tx_valid, mem_rd_req}, 32'h0);
        for (int e = 0; e < 4; e++) begin
            reg_read(4'(e * 4 + 2), d);
            chk(d == 32'(CB_INIT << 2), "R1 control word after reset", d, 32'(CB_INIT << 2));
        end

        // R3: entry at ring position without enable stays idle
        reg_write(4'(CB_INIT * 4 + 1), 32'd5);
        reg_write(4'(CB_INIT * 4 + 2), 32'h0000_1000);
        b0 = n_bytes; r0 = n_reqs;
        repeat (12) @(negedge clk);
        chk(n_bytes == b0 && n_reqs == r0, "R3 no activity while enable is 0",
            32'(n_bytes - b0 + n_reqs - r0), 32'h0);
        reg_read(4'(1 * 4 + 2), d);
        chk(d[3:2] == 2'(CB_INIT), "R3 ring position unchanged while idle", {30'b0, d[3:2]}, 32'(CB_INIT));

        // R4 R5: frame at entry 2, success
        queue_frame(2, 32'h0000_1000, 32'd5, 1'b0);
        wait_done(2);
        reg_read(4'(2 * 4 + 2), d);
        chk(d == (32'h0000_1000 | 32'h2 | (32'd3 << 2)), "R5 control word after completion",
            d, 32'h0000_1000 | 32'h2 | (32'd3 << 2));
        reg_read(4'(2 * 4 + 0), d);
        chk(d == 32'h0, "R5 status clean frame", d, 32'h0);
        chk(irq, "R8 level with a done flag", {31'b0, irq}, 32'h1);

        // R7: done write semantics
        reg_write(4'(2 * 4 + 2), 32'h0000_1000 | 32'h2);
        reg_read(4'(2 * 4 + 2), d);
        chk(d[1], "R7 writing 1 keeps done", {31'b0, d[1]}, 32'h1);
        reg_write(4'(2 * 4 + 2), 32'h0000_1000);
        reg_read(4'(2 * 4 + 2), d);
        chk(!d[1], "R7 writing 0 clears done", {31'b0, d[1]}, 32'h0);
        chk(!irq, "R8 level low with no done flag", {31'b0, irq}, 32'h0);
        reg_write(4'(2 * 4 + 2), 32'h0000_1000 | 32'h2);
        reg_read(4'(2 * 4 + 2), d);
        chk(!d[1], "R7 writing 1 never sets done", {31'b0, d[1]}, 32'h0);

        // R2 R4 R5: two frames queued back to back, wrap from 3 to 0, upper length bits
        queue_frame(3, 32'h0000_2040, 32'd3, 1'b1);
        queue_frame(0, 32'h0000_3FE0, 32'h0000_0827, 1'b0);
        wait_done(3);
        wait_done(0);
        reg_read(4'(3 * 4 + 0), d);
        chk(d == 32'h1, "R5 status carries abort", d, 32'h1);
        reg_read(4'(0 * 4 + 0), d);
        chk(d == 32'h0, "R5 status of second frame", d, 32'h0);
        reg_read(4'(0 * 4 + 2), d);
        chk(d[3:2] == 2'd1 && !d[0], "R2 wrap to entry 1 and enable cleared", {28'b0, d[3:0]}, 32'h6);
        chk(n_bytes == 5 + 3 + 39 && exp_q.size() == 0, "R4 total bytes streamed",
            32'(n_bytes), 32'd47);

        reg_write(4'(3 * 4 + 2), 32'h0000_2040);
        reg_write(4'(0 * 4 + 2), 32'h0000_3FE0);
        chk(!irq, "R8 level low after clearing all", {31'b0, irq}, 32'h0);

        // R6: zero length entry at position 1
        b0 = n_bytes; r0 = n_reqs;
        reg_write(4'(1 * 4 + 0), 32'h0);
        reg_write(4'(1 * 4 + 1), 32'h0);
        reg_write(4'(1 * 4 + 2), 32'h0000_4000 | 32'h1);
        reg_read(4'(1 * 4 + 2), d);
        chk(d[1:0] == 2'b01, "R6 one edge after write not yet done", {30'b0, d[1:0]}, 32'h1);
        @(negedge clk);
        reg_read(4'(1 * 4 + 2), d);
        chk(d[1:0] == 2'b10 && d[3:2] == 2'd2, "R6 completes on the following edge", {28'b0, d[3:0]}, 32'hA);
        chk(irq_pulse && irq, "R8 pulse for zero length completion", {30'b0, irq, irq_pulse}, 32'h3);
        reg_read(4'(1 * 4 + 0), d);
        chk(d == 32'h1, "R6 status abort for zero length", d, 32'h1);
        repeat (4) @(negedge clk);
        chk(n_bytes == b0 && n_reqs == r0, "R6 no reads or bytes for zero length",
            32'(n_bytes - b0 + n_reqs - r0), 32'h0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule